// File: doc/BRIEF.md
# Four-Channel ADC Sweep Sequencer

This block runs a parallel-bus, register-configurable 10-bit analog-to-digital converter through a fixed sweep of its analog channels. A free-running range-gate counter produces a gate pulse every short or long period, selected by `gate_sel`. The gate pulse arms the sequencer. A rising edge on the sampling-start input is accepted only while the block is armed and idle. Once a start is accepted, the block lowers chip select and services each channel in turn. For every channel it writes two configuration words to the converter over the shared bidirectional bus, waits for the converter's active-low completion line, and pulses a read strobe to capture the 10-bit result.

Each captured result leaves the block with its channel tag and a one-cycle valid strobe. The strobe for the last channel also carries an end-of-sweep flag. After the last channel the block releases chip select and stays idle until a new rising edge arrives in a later gate period. If the converter never signals completion within a bounded wait, the block raises an error flag and abandons the sweep.

States of the controller: `ST_IDLE` (chip select high), `ST_WRA` (first write strobe), `ST_GAPA` (strobe high, first word still driven), `ST_WRB` (second write strobe), `ST_GAPB` (strobe high, second word still driven), `ST_WAIT` (awaiting completion), `ST_READ` (read strobe), `ST_NEXT` (result presented). Transitions: IDLE→WRA on an accepted start. WRA→GAPA and WRB→GAPB after the strobe length. GAPA→WRB and GAPB→WAIT after one cycle. WAIT→READ when the completion line is low. WAIT→IDLE on timeout. READ→NEXT after the strobe length. NEXT→WRA for the following channel, or NEXT→IDLE after the last channel.

Top module: `adc_seq_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `adc_cs_n`, `adc_wr_n` and `adc_rd_n` are 1, and `sample_vld`, `sweep_end`, `err` and `gate_pulse` are 0.
- R2: `gate_pulse` is high for one cycle once every GATE_SHORT_CYC cycles when `gate_sel`=0 and once every GATE_LONG_CYC cycles when `gate_sel`=1. A start edge is accepted only if a gate pulse has occurred since the previous accepted start. An edge that arrives without that is ignored.
- R3: After an accepted start edge, `adc_cs_n` goes low in the next cycle. It stays low until the sweep completes or times out.
- R4: For each channel, `adc_wr_n` goes low twice, each time for STROBE_CYC cycles, with one high cycle after each strobe. During the first strobe and the high cycle after it the bus carries {8'b00110000, channel[1:0]}. During the second strobe and the high cycle after it the bus carries 10'b0100000100.
- R5: After the second write, the block waits for `adc_int_n`=0. It then holds `adc_rd_n` low for STROBE_CYC cycles and captures the bus on the last of them. In the cycle after that, `sample_vld` is 1 for exactly one cycle with the captured value on `sample`.
- R6: Channels are served in the order 0, 1, 2, 3 and the block then returns to idle. `sample_ch` carries the channel of each result. `sweep_end` is 1 with the channel-3 result and 0 with the others.
- R7: The block drives `adc_data` only during the write strobes and the cycle after each, and only while `bus_en`=1. At all other times it leaves the bus to other drivers.
- R8: If `adc_int_n` stays high for TIMEOUT_CYC cycles of waiting, `err` rises, `adc_cs_n` returns to 1 in the same cycle, and the block idles. `err` stays high until the next accepted start clears it.
- R9: A start input held high starts at most one sweep. Starting again requires a new 0-to-1 transition.
- R10: `adc_wr_n` and `adc_rd_n` are never low together, and neither is low while `adc_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_sel | input | 1 | Range-gate period select: 0 short, 1 long |
| samp_start | input | 1 | Sampling-start request, acted on at its rising edge |
| bus_en | input | 1 | Bus enable; when low the block never drives the data bus |
| adc_int_n | input | 1 | Converter conversion-complete line, active low |
| adc_data | inout | 10 | Shared converter data bus |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_wr_n | output | 1 | Converter write strobe, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| gate_pulse | output | 1 | One-cycle range-gate pulse |
| sample | output | 10 | Last captured conversion result |
| sample_ch | output | 2 | Channel of the last captured result |
| sample_vld | output | 1 | One-cycle strobe marking a new result |
| sweep_end | output | 1 | Set with the result of the final channel |
| err | output | 1 | Completion timeout seen; held until next start |

## Verification
A wrong state or a stuck timer shows at the strobe pins within one cycle. Either the low period of `adc_wr_n` or `adc_rd_n` has the wrong length, or the bus word for the current phase is wrong. A channel counter that skips or repeats a channel shows first as a wrong low bits in the first configuration word, several cycles before a mistagged `sample_ch` appears. Faults in arming or in edge detection show only at the next start request, as chip select falling when it should stay high or staying high when it should fall. Because of this, the reference model compares every port on every cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int DATA_W = 10;
    localparam int CH_W   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRA,
        ST_GAPA,
        ST_WRB,
        ST_GAPB,
        ST_WAIT,
        ST_READ,
        ST_NEXT
    } seq_state_t;

    localparam logic [DATA_W-CH_W-1:0] CFG_A_HEAD = 8'b0011_0000;
    localparam logic [DATA_W-1:0]      CFG_B_WORD = 10'b01_0000_0100;

    localparam logic [1:0] WIDX_NONE = 2'b00;
    localparam logic [1:0] WIDX_A    = 2'b01;
    localparam logic [1:0] WIDX_B    = 2'b10;

endpackage

// File: rtl/adc_gate_arm.sv
module adc_gate_arm #(
    parameter int GATE_SHORT_CYC = 51200,
    parameter int GATE_LONG_CYC  = 102400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_sel,
    input  logic samp_start,
    input  logic idle,
    output logic accept,
    output logic gate_pulse
);

    localparam int GW = $clog2(GATE_LONG_CYC) + 1;
    localparam logic [GW-1:0] SHORT_LAST = GW'(GATE_SHORT_CYC - 1);
    localparam logic [GW-1:0] LONG_LAST  = GW'(GATE_LONG_CYC - 1);

    logic [GW-1:0] gate_cnt;
    logic          start_q;
    logic          armed;
    logic          wrap;
    logic          rise;

    assign wrap   = gate_cnt >= (gate_sel ? LONG_LAST : SHORT_LAST);
    assign rise   = samp_start & ~start_q;
    assign accept = rise & armed & idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_cnt   <= '0;
            gate_pulse <= 1'b0;
            start_q    <= 1'b0;
            armed      <= 1'b0;
        end else begin
            start_q    <= samp_start;
            gate_pulse <= wrap;
            gate_cnt   <= wrap ? '0 : gate_cnt + 1'b1;
            if (wrap) begin
                armed <= 1'b1;
            end else if (accept) begin
                armed <= 1'b0;
            end
        end
    end

    AST_GATE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        gate_pulse |=> !gate_pulse); // R2

    AST_ACCEPT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept); // R9

endmodule

// File: rtl/adc_cfg_word.sv
module adc_cfg_word
    import adc_seq_pkg::*;
(
    input  logic [1:0]        wr_idx,
    input  logic [CH_W-1:0]   ch,
    output logic [DATA_W-1:0] word
);

    always_comb begin
        unique case (wr_idx)
            WIDX_B:  word = CFG_B_WORD;
            WIDX_A:  word = {CFG_A_HEAD, ch};
            default: word = {CFG_A_HEAD, ch};
        endcase
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int STROBE_CYC  = 3,
    parameter int TIMEOUT_CYC = 4096,
    parameter int NUM_CH      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              int_n,
    input  logic [DATA_W-1:0] rd_data,
    output logic              idle,
    output logic              cs_n,
    output logic              wr_n,
    output logic              rd_n,
    output logic [1:0]        wr_idx,
    output logic [CH_W-1:0]   ch,
    output logic [DATA_W-1:0] sample,
    output logic [CH_W-1:0]   sample_ch,
    output logic              sample_vld,
    output logic              sweep_end,
    output logic              err
);

    localparam int MAXC = (TIMEOUT_CYC > STROBE_CYC) ? TIMEOUT_CYC : STROBE_CYC;
    localparam int TW   = $clog2(MAXC) + 1;
    localparam logic [TW-1:0]   STRB_LAST = TW'(STROBE_CYC - 1);
    localparam logic [TW-1:0]   TMO_LAST  = TW'(TIMEOUT_CYC - 1);
    localparam logic [CH_W-1:0] LAST_CH   = CH_W'(NUM_CH - 1);

    seq_state_t    state, nxt;
    logic [TW-1:0] tmr;
    logic          tmr_clr;
    logic          to_err;
    logic          capture;
    logic          ch_inc;
    logic          start_q;
    logic          go;

    assign idle = (state == ST_IDLE);
    assign go   = idle & accept;

    always_comb begin
        nxt     = state;
        tmr_clr = 1'b0;
        to_err  = 1'b0;
        capture = 1'b0;
        ch_inc  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    nxt     = ST_WRA;
                    tmr_clr = 1'b1;
                end
            end
            ST_WRA: begin
                if (tmr == STRB_LAST) begin
                    nxt     = ST_GAPA;
                    tmr_clr = 1'b1;
                end
            end
            ST_GAPA: begin
                nxt     = ST_WRB;
                tmr_clr = 1'b1;
            end
            ST_WRB: begin
                if (tmr == STRB_LAST) begin
                    nxt     = ST_GAPB;
                    tmr_clr = 1'b1;
                end
            end
            ST_GAPB: begin
                nxt     = ST_WAIT;
                tmr_clr = 1'b1;
            end
            ST_WAIT: begin
                if (!int_n) begin
                    nxt     = ST_READ;
                    tmr_clr = 1'b1;
                end else if (tmr == TMO_LAST) begin
                    nxt     = ST_IDLE;
                    to_err  = 1'b1;
                    tmr_clr = 1'b1;
                end
            end
            ST_READ: begin
                if (tmr == STRB_LAST) begin
                    nxt     = ST_NEXT;
                    capture = 1'b1;
                    tmr_clr = 1'b1;
                end
            end
            ST_NEXT: begin
                tmr_clr = 1'b1;
                if (ch == LAST_CH) begin
                    nxt = ST_IDLE;
                end else begin
                    nxt    = ST_WRA;
                    ch_inc = 1'b1;
                end
            end
            default: begin
                nxt     = ST_IDLE;
                tmr_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tmr     <= '0;
            ch      <= '0;
            start_q <= 1'b0;
        end else begin
            state <= nxt;
            tmr   <= tmr_clr ? '0 : tmr + 1'b1;
            if (go) begin
                ch      <= '0;
                start_q <= 1'b1;
            end else begin
                if (ch_inc) begin
                    ch <= ch + 1'b1;
                end
                if (nxt == ST_IDLE) begin
                    start_q <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample     <= '0;
            sample_ch  <= '0;
            sample_vld <= 1'b0;
            sweep_end  <= 1'b0;
            err        <= 1'b0;
        end else begin
            sample_vld <= capture;
            if (capture) begin
                sample    <= rd_data;
                sample_ch <= ch;
                sweep_end <= (ch == LAST_CH);
            end
            if (to_err) begin
                err <= 1'b1;
            end else if (go) begin
                err <= 1'b0;
            end
        end
    end

    always_comb begin
        cs_n   = ~start_q;
        wr_n   = ~((state == ST_WRA) || (state == ST_WRB));
        rd_n   = ~(state == ST_READ);
        wr_idx = WIDX_NONE;
        if ((state == ST_WRA) || (state == ST_GAPA)) begin
            wr_idx = WIDX_A;
        end else if ((state == ST_WRB) || (state == ST_GAPB)) begin
            wr_idx = WIDX_B;
        end
    end

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |=> !sample_vld); // R5

    AST_VLD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> ($past(rd_n) == 1'b0)); // R5

    AST_ERR_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> cs_n); // R8

    AST_START_LOWERS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !cs_n); // R3

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int STROBE_CYC     = 3,
    parameter int TIMEOUT_CYC    = 4096,
    parameter int NUM_CH         = 4,
    parameter int GATE_SHORT_CYC = 51200,
    parameter int GATE_LONG_CYC  = 102400
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gate_sel,
    input  logic                 samp_start,
    input  logic                 bus_en,
    input  logic                 adc_int_n,
    inout  wire  [DATA_W-1:0]    adc_data,
    output logic                 adc_cs_n,
    output logic                 adc_wr_n,
    output logic                 adc_rd_n,
    output logic                 gate_pulse,
    output logic [DATA_W-1:0]    sample,
    output logic [CH_W-1:0]      sample_ch,
    output logic                 sample_vld,
    output logic                 sweep_end,
    output logic                 err
);

    logic              accept;
    logic              idle;
    logic [1:0]        wr_idx;
    logic [CH_W-1:0]   ch;
    logic [DATA_W-1:0] cfg_word;
    logic              drive;

    adc_gate_arm #(
        .GATE_SHORT_CYC (GATE_SHORT_CYC),
        .GATE_LONG_CYC  (GATE_LONG_CYC)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_sel   (gate_sel),
        .samp_start (samp_start),
        .idle       (idle),
        .accept     (accept),
        .gate_pulse (gate_pulse)
    );

    adc_seq_fsm #(
        .STROBE_CYC  (STROBE_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .NUM_CH      (NUM_CH)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .int_n      (adc_int_n),
        .rd_data    (adc_data),
        .idle       (idle),
        .cs_n       (adc_cs_n),
        .wr_n       (adc_wr_n),
        .rd_n       (adc_rd_n),
        .wr_idx     (wr_idx),
        .ch         (ch),
        .sample     (sample),
        .sample_ch  (sample_ch),
        .sample_vld (sample_vld),
        .sweep_end  (sweep_end),
        .err        (err)
    );

    adc_cfg_word u_word (
        .wr_idx (wr_idx),
        .ch     (ch),
        .word   (cfg_word)
    );

    assign drive    = bus_en && (wr_idx != WIDX_NONE);
    assign adc_data = drive ? cfg_word : {DATA_W{1'bz}};

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!adc_wr_n && !adc_rd_n)); // R10

    AST_CS_COVERS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_wr_n || !adc_rd_n) |-> !adc_cs_n); // R10

    AST_SWEEP_END_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> (sweep_end == (sample_ch == CH_W'(NUM_CH - 1)))); // R6

    AST_NO_DRIVE_WHILE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> !drive); // R7

endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;

    localparam int CLK_PER = 10;
    localparam int STRB    = 2;
    localparam int TMO     = 24;
    localparam int SHORT   = 60;
    localparam int LONG    = 120;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gate_sel = 1'b0;
    logic       samp_start = 1'b0;
    logic       bus_en = 1'b1;
    logic       adc_int_n = 1'b1;
    wire  [9:0] adc_data;
    logic       adc_cs_n, adc_wr_n, adc_rd_n, gate_pulse;
    logic [9:0] sample;
    logic [1:0] sample_ch;
    logic       sample_vld, sweep_end, err;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    logic [9:0] adc_val = 10'h000;
    int         conv_dly = 3;
    int         conv_cnt = 0;
    int         wr_cnt = 0;
    logic       wr_prev = 1'b1;
    int         seed = 1;

    always #(CLK_PER/2) clk = ~clk;

    assign adc_data = (!adc_rd_n) ? adc_val : (!bus_en ? 10'h155 : 10'bz);

    adc_seq_ctrl #(
        .STROBE_CYC     (STRB),
        .TIMEOUT_CYC    (TMO),
        .NUM_CH         (4),
        .GATE_SHORT_CYC (SHORT),
        .GATE_LONG_CYC  (LONG)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_sel   (gate_sel),
        .samp_start (samp_start),
        .bus_en     (bus_en),
        .adc_int_n  (adc_int_n),
        .adc_data   (adc_data),
        .adc_cs_n   (adc_cs_n),
        .adc_wr_n   (adc_wr_n),
        .adc_rd_n   (adc_rd_n),
        .gate_pulse (gate_pulse),
        .sample     (sample),
        .sample_ch  (sample_ch),
        .sample_vld (sample_vld),
        .sweep_end  (sweep_end),
        .err        (err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // converter model, acts on falling edges
    always @(negedge clk) begin
        if (adc_cs_n) begin
            conv_cnt  = 0;
            wr_cnt    = 0;
            adc_int_n = 1'b1;
        end else begin
            if (!adc_rd_n) adc_int_n = 1'b1;
            if (!wr_prev && adc_wr_n) begin
                wr_cnt++;
                if (wr_cnt % 2 == 0) conv_cnt = conv_dly;
            end
            if (conv_cnt > 0) begin
                conv_cnt--;
                if (conv_cnt == 0) begin
                    adc_int_n = 1'b0;
                    seed++;
                    adc_val = 10'((seed * 37 + 5) % 1024);
                end
            end
        end
        wr_prev = adc_wr_n;
    end

    // behavioural reference model
    int   m_st = 0, m_t = 0, m_ch = 0, m_gcnt = 0;
    bit   m_sq = 0, m_armed = 0, m_gp = 0, m_vld = 0, m_send = 0, m_err = 0;
    int   m_sample = 0, m_sch = 0;

    always @(posedge clk) begin
        bit rise, wrap, acc;
        int per;
        if (!rst_n) begin
            m_st = 0; m_t = 0; m_ch = 0; m_gcnt = 0; m_sq = 0; m_armed = 0;
            m_gp = 0; m_vld = 0; m_send = 0; m_err = 0; m_sample = 0; m_sch = 0;
        end else begin
            per  = gate_sel ? LONG : SHORT;
            rise = samp_start && !m_sq;
            m_sq = samp_start;
            wrap = (m_gcnt >= per - 1);
            acc  = rise && m_armed && (m_st == 0);
            m_vld = 0;
            case (m_st)
                0: if (acc) begin m_st = 1; m_t = 0; m_ch = 0; m_err = 0; end
                1: if (m_t == STRB - 1) begin m_st = 2; m_t = 0; end else m_t++;
                2: begin m_st = 3; m_t = 0; end
                3: if (m_t == STRB - 1) begin m_st = 4; m_t = 0; end else m_t++;
                4: begin m_st = 5; m_t = 0; end
                5: if (!adc_int_n) begin m_st = 6; m_t = 0; end
                   else if (m_t == TMO - 1) begin m_st = 0; m_t = 0; m_err = 1; end
                   else m_t++;
                6: if (m_t == STRB - 1) begin
                       m_st = 7; m_t = 0; m_vld = 1;
                       m_sample = adc_val; m_sch = m_ch; m_send = (m_ch == 3);
                   end else m_t++;
                7: begin
                       m_t = 0;
                       if (m_ch == 3) m_st = 0;
                       else begin m_ch++; m_st = 1; end
                   end
                default: m_st = 0;
            endcase
            if (wrap) m_armed = 1; else if (acc) m_armed = 0;
            m_gcnt = wrap ? 0 : m_gcnt + 1;
            m_gp = wrap;
        end
        #(CLK_PER/4);
        if (rst_n && !done) begin
            bit e_cs, e_wr, e_rd;
            e_cs = (m_st == 0);
            e_wr = !(m_st == 1 || m_st == 3);
            e_rd = !(m_st == 6);
            chk(adc_cs_n === e_cs, "R3/R9 cs_n", adc_cs_n, e_cs);
            chk(adc_wr_n === e_wr, "R4 wr_n", adc_wr_n, e_wr);
            chk(adc_rd_n === e_rd, "R5 rd_n", adc_rd_n, e_rd);
            chk(sample_vld === m_vld, "R5 sample_vld", sample_vld, m_vld);
            chk(err === m_err, "R8 err", err, m_err);
            chk(gate_pulse === m_gp, "R2 gate_pulse", gate_pulse, m_gp);
            chk(!(!adc_wr_n && !adc_rd_n) && (adc_cs_n ? (adc_wr_n && adc_rd_n) : 1'b1),
                "R10 strobes", {adc_cs_n, adc_wr_n, adc_rd_n}, 0);
            if (m_vld) begin
                chk(sample === 10'(m_sample), "R5 sample", sample, m_sample);
                chk(sample_ch === 2'(m_sch), "R6 sample_ch", sample_ch, m_sch);
                chk(sweep_end === m_send, "R6 sweep_end", sweep_end, m_send);
            end
            if (m_st >= 1 && m_st <= 4) begin
                logic [9:0] e_w;
                e_w = (m_st <= 2) ? {8'b0011_0000, 2'(m_ch)} : 10'b01_0000_0100;
                if (bus_en) chk(adc_data === e_w, "R4 bus word", adc_data, e_w);
                else chk(adc_data === 10'h155, "R7 bus release", adc_data, 10'h155);
            end
        end
    end

    task automatic wait_gate();
        @(negedge clk);
        while (gate_pulse !== 1'b1) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); samp_start = 1'b1;
        @(negedge clk); samp_start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (adc_cs_n !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values during reset
        chk(adc_cs_n === 1 && adc_wr_n === 1 && adc_rd_n === 1, "R1 strobes in reset",
            {adc_cs_n, adc_wr_n, adc_rd_n}, 7);
        chk(sample_vld === 0 && sweep_end === 0 && err === 0 && gate_pulse === 0,
            "R1 flags in reset", {sample_vld, sweep_end, err, gate_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_cs_n === 1 && sample_vld === 0 && err === 0, "R1 after reset",
            {adc_cs_n, sample_vld, err}, 4);

        // start before any gate pulse: not armed (R2)
        pulse_start();
        repeat (3) @(negedge clk);
        chk(adc_cs_n === 1, "R2 unarmed start ignored", adc_cs_n, 1);

        // normal sweep with a stray start mid-sweep (R3, R4, R5, R6)
        wait_gate();
        pulse_start();
        repeat (10) @(negedge clk);
        pulse_start();
        wait_idle();

        // varied conversion delays and bus release (R7)
        conv_dly = 1;
        wait_gate();
        pulse_start();
        repeat (4) @(negedge clk);
        bus_en = 1'b0;
        repeat (6) @(negedge clk);
        bus_en = 1'b1;
        conv_dly = 6;
        wait_idle();

        // long gate: second start in same period ignored (R2)
        gate_sel = 1'b1;
        conv_dly = 2;
        wait_gate();
        pulse_start();
        wait_idle();
        pulse_start();
        repeat (3) @(negedge clk);
        chk(adc_cs_n === 1, "R2 same-period start ignored", adc_cs_n, 1);

        // timeout (R8)
        conv_dly = 1000;
        wait_gate();
        pulse_start();
        wait_idle();
        chk(err === 1, "R8 err after timeout", err, 1);
        repeat (5) @(negedge clk);
        chk(err === 1, "R8 err held", err, 1);

        // recovery clears err, with conversion near timeout limit (R8)
        conv_dly = TMO - 2;
        wait_gate();
        pulse_start();
        @(negedge clk);
        chk(err === 0, "R8 err cleared by start", err, 0);
        wait_idle();

        // held start: one sweep only (R9)
        gate_sel = 1'b0;
        conv_dly = 3;
        wait_gate();
        @(negedge clk); samp_start = 1'b1;
        begin
            int falls = 0;
            logic prev = 1'b1;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (prev && !adc_cs_n) falls++;
                prev = adc_cs_n;
            end
            chk(falls == 1, "R9 held start sweeps once", falls, 1);
        end
        samp_start = 1'b0;
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule